// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block keeps a 32-bit running count of seconds. A separate prescaler sends it a one-cycle tick strobe once per second. Software can reload the count at any time and can program a match value. When the count lands on the match value, a sticky raw alarm flag is set. The flag is gated by a one-bit mask onto a level interrupt line and stays set until software writes to the clear location. The block is always running and has no enable.

Software uses a single-beat register port with 12-bit byte offsets. Requests travel over a valid/ready pair. `req_ready` is tied high, so the block never applies back-pressure, and every beat with `req_valid` high counts as accepted in that cycle. A read returns its data with `rsp_valid` one cycle after it is accepted. A write produces no response beat. Read data shows the register state as it was before the accepting edge. The top 32 bytes of the window hold a fixed eight-byte identification table.

Top module: `sec_alarm_counter`

## Requirements
- R1: `req_ready` is always 1. An accepted read (`req_valid`=1, `req_write`=0) gives `rsp_valid`=1 with its data in the next cycle. An accepted write leaves `rsp_valid`=0 in the next cycle. An offset with nonzero bits [1:0] matches no register.
- R2: After reset the count, load, match, mask and raw flag are all 0 and `irq` is low. Count equal to match at reset does not set the flag.
- R3: A write to offset 0x08 loads the written value into the count. Each later tick adds 1. A load in the same cycle as a tick wins. Reading 0x08 returns the last value written there. Reading 0x00 returns the count.
- R4: The count wraps from 0xFFFFFFFF to 0. A match value numerically below the count still fires once the count wraps to it.
- R5: On a tick cycle where the incremented count equals the match register (offset 0x04), the raw flag sets. Offset 0x14 reads it in bit 0.
- R6: A write to 0x04 or 0x08 that leaves the count equal to the match value sets the raw flag in that same cycle.
- R7: A write to 0x10 stores only data bit 0 as the mask. Reads of 0x10 return that bit with all other bits 0.
- R8: Offset 0x18 reads the raw flag AND the mask in bit 0, and `irq` carries the same value.
- R9: Any write to 0x1C clears the raw flag, whatever the data. If a set condition happens in the same cycle, the set wins.
- R10: Offset 0x0C always reads 1, and writes to it change nothing.
- R11: Reads of 0xFE0, 0xFE4, … 0xFFC return 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order.
- R12: Writes to 0x00, 0x14 and 0x18 have no effect.
- R13: Reads of 0x1C and of any offset that is not defined return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle per-second strobe |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level alarm interrupt |

## Verification
The bench targets the alarm's corner cases:
- **Match below the count, reached across the wrap.** A design using a magnitude compare would never fire here.
- **Immediate firing.** A match or load write that lands equal to the count must set the flag at once. A design that checked only on ticks would stay silent.
- **Clear and set in the same cycle.** A clear-priority design would lose the alarm.
- **Clear data ignored.** A design that tested a data bit would keep the flag when 0 is written.

It also sweeps every undefined word offset and all identification bytes. It confirms that the read-only and control locations ignore writes, and checks the mask against both values of the raw flag.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_MATCH = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_MSKD  = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h01C;
  localparam int ID_BYTES = 8;
  localparam int ID_IDX_W = $clog2(ID_BYTES);

  function automatic logic [7:0] id_byte(input logic [ID_IDX_W-1:0] idx);
    case (idx)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/sac_count_core.sv
module sac_count_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ld_we_i,
  input  logic [DATA_W-1:0] ld_val_i,
  output logic [DATA_W-1:0] cnt_q_o,
  output logic [DATA_W-1:0] cnt_nxt_o,
  output logic [DATA_W-1:0] ld_q_o
);
  logic [DATA_W-1:0] cnt_q, ld_q;

  always_comb begin
    if (ld_we_i)     cnt_nxt_o = ld_val_i;
    else if (tick_i) cnt_nxt_o = cnt_q + DATA_W'(1);
    else             cnt_nxt_o = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ld_q  <= '0;
    end else begin
      cnt_q <= cnt_nxt_o;
      if (ld_we_i) ld_q <= ld_val_i;
    end
  end

  assign cnt_q_o = cnt_q;
  assign ld_q_o  = ld_q;

  // R3
  load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we_i |=> cnt_q == $past(ld_val_i));
  // R4
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !ld_we_i) |=> cnt_q == $past(cnt_q) + DATA_W'(1));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !ld_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sac_alarm.sv
module sac_alarm #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ld_we_i,
  input  logic              mr_we_i,
  input  logic [DATA_W-1:0] mr_val_i,
  input  logic [DATA_W-1:0] cnt_nxt_i,
  input  logic              clr_we_i,
  input  logic              msk_we_i,
  input  logic              msk_bit_i,
  output logic [DATA_W-1:0] mr_q_o,
  output logic              raw_q_o,
  output logic              mask_q_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mr_q, mr_nxt;
  logic raw_q, mask_q, evt, hit;

  assign mr_nxt = mr_we_i ? mr_val_i : mr_q;
  assign evt    = tick_i | ld_we_i | mr_we_i;
  assign hit    = evt && (cnt_nxt_i == mr_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q   <= '0;
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      mr_q <= mr_nxt;
      if (hit)           raw_q <= 1'b1;
      else if (clr_we_i) raw_q <= 1'b0;
      if (msk_we_i) mask_q <= msk_bit_i;
    end
  end

  assign mr_q_o   = mr_q;
  assign raw_q_o  = raw_q;
  assign mask_q_o = mask_q;
  assign irq_o    = raw_q & mask_q;

  // R9
  raw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clr_we_i) |=> raw_q);
  // R5
  raw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(evt));
  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msk_we_i |=> $stable(mask_q));
endmodule

// File: rtl/sac_regif.sv
module sac_regif
  import sac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic [DATA_W-1:0] ld_i,
  input  logic [DATA_W-1:0] mr_i,
  input  logic              mask_i,
  input  logic              raw_i,
  output logic              ld_we_o,
  output logic              mr_we_o,
  output logic              msk_we_o,
  output logic              clr_we_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic              aligned, wr_acc, rd_acc, id_hit;
  logic [WORD_W-1:0] word;
  logic [DATA_W-1:0] rd_val, rdata_q;
  logic              rvalid_q;

  assign aligned = (req_addr_i[1:0] == 2'b00);
  assign word    = req_addr_i[ADDR_W-1:2];
  assign wr_acc  = req_valid_i &  req_write_i & aligned;
  assign rd_acc  = req_valid_i & ~req_write_i;
  assign id_hit  = (req_addr_i[ADDR_W-1:5] == '1);

  assign ld_we_o  = wr_acc && (word == OFS_LOAD[ADDR_W-1:2]);
  assign mr_we_o  = wr_acc && (word == OFS_MATCH[ADDR_W-1:2]);
  assign msk_we_o = wr_acc && (word == OFS_MASK[ADDR_W-1:2]);
  assign clr_we_o = wr_acc && (word == OFS_CLR[ADDR_W-1:2]);

  always_comb begin
    rd_val = '0;
    if (aligned) begin
      if (id_hit) begin
        rd_val = DATA_W'(id_byte(req_addr_i[ID_IDX_W+1:2]));
      end else begin
        case (word)
          OFS_COUNT[ADDR_W-1:2]: rd_val = cnt_i;
          OFS_MATCH[ADDR_W-1:2]: rd_val = mr_i;
          OFS_LOAD[ADDR_W-1:2]:  rd_val = ld_i;
          OFS_CTRL[ADDR_W-1:2]:  rd_val = DATA_W'(1);
          OFS_MASK[ADDR_W-1:2]:  rd_val = DATA_W'(mask_i);
          OFS_RAW[ADDR_W-1:2]:   rd_val = DATA_W'(raw_i);
          OFS_MSKD[ADDR_W-1:2]:  rd_val = DATA_W'(raw_i & mask_i);
          default:               rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) rdata_q <= rd_val;
    end
  end

  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;

  // R1
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid_o);
  // R1
  no_wr_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i) |=> !rsp_valid_o);
  // R10
  ctrl_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && req_addr_i == OFS_CTRL) |=> rsp_rdata_o == DATA_W'(1));
endmodule

// File: rtl/sec_alarm_counter.sv
module sec_alarm_counter
  import sac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] cnt_q, cnt_nxt, ld_q, mr_q;
  logic ld_we, mr_we, msk_we, clr_we, raw_q, mask_q;

  assign req_ready = 1'b1;

  sac_regif #(.DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .cnt_i(cnt_q), .ld_i(ld_q), .mr_i(mr_q),
    .mask_i(mask_q), .raw_i(raw_q),
    .ld_we_o(ld_we), .mr_we_o(mr_we), .msk_we_o(msk_we), .clr_we_o(clr_we),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata)
  );

  sac_count_core #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .ld_we_i(ld_we), .ld_val_i(req_wdata),
    .cnt_q_o(cnt_q), .cnt_nxt_o(cnt_nxt), .ld_q_o(ld_q)
  );

  sac_alarm #(.DATA_W(DATA_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .ld_we_i(ld_we), .mr_we_i(mr_we), .mr_val_i(req_wdata),
    .cnt_nxt_i(cnt_nxt), .clr_we_i(clr_we),
    .msk_we_i(msk_we), .msk_bit_i(req_wdata[0]),
    .mr_q_o(mr_q), .raw_q_o(raw_q), .mask_q_o(mask_q), .irq_o(irq)
  );

  // R6
  match_write_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_we && req_wdata == cnt_nxt) |=> raw_q);
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we && !msk_we && raw_q && mask_q) |=> irq);
endmodule

// File: tb/sec_alarm_counter_tb_top.sv
module sec_alarm_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sec_alarm_counter dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit with_tick = 0);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; tick = with_tick;
    @(negedge clk);
    req_valid = 0; req_write = 0; tick = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check(req, {31'd0, rsp_valid}, 32'd1);
    check(req, rsp_rdata, exp);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    check("R2 irq", {31'd0, irq}, 0);
    rd(12'h000, 0, "R2 count"); rd(12'h004, 0, "R2 match");
    rd(12'h008, 0, "R2 load");  rd(12'h010, 0, "R2 mask");
    rd(12'h014, 0, "R2 raw");   rd(12'h018, 0, "R2 masked");
    // R1 handshake
    check("R1 ready", {31'd0, req_ready}, 1);
    wr(12'h00C, 32'h5);
    check("R1 no write rsp", {31'd0, rsp_valid}, 0);
    rd(12'h002, 0, "R1 unaligned");
    // R3 load and count
    wr(12'h008, 100);
    rd(12'h000, 100, "R3 loaded");
    rd(12'h014, 0, "R3 no alarm");
    tk(3);
    rd(12'h000, 103, "R3 ticks");
    rd(12'h008, 100, "R3 load readback");
    wr(12'h008, 200, 1);
    rd(12'h000, 200, "R3 load beats tick");
    wr(12'h008, 103);
    // R12 read-only count
    wr(12'h000, 55);
    rd(12'h000, 103, "R12 count write ignored");
    // R10 control
    rd(12'h00C, 1, "R10 control");
    // R7 mask
    wr(12'h010, 32'hFFFFFFFF); rd(12'h010, 1, "R7 mask all ones");
    wr(12'h010, 32'hFFFFFFFE); rd(12'h010, 0, "R7 mask bit0 clear");
    wr(12'h010, 1);
    // R5 alarm on tick
    wr(12'h004, 105);
    rd(12'h014, 0, "R5 not yet");
    tk(1);
    check("R5 irq low at 104", {31'd0, irq}, 0);
    tk(1);
    rd(12'h014, 1, "R5 raw at match");
    check("R8 irq", {31'd0, irq}, 1);
    // R12 status writes ignored
    wr(12'h014, 0); rd(12'h014, 1, "R12 raw write ignored");
    wr(12'h018, 0); rd(12'h014, 1, "R12 masked write ignored");
    // R8 sweep of mask with raw=1 and raw=0
    for (int r = 1; r >= 0; r--) begin
      for (int m = 0; m < 2; m++) begin
        wr(12'h010, m);
        rd(12'h018, r & m, "R8 masked read");
        check("R8 irq level", {31'd0, irq}, r & m);
      end
      if (r == 1) wr(12'h01C, 0); // R9 clear with zero data
      if (r == 1) rd(12'h014, 0, "R9 clear any data");
    end
    // R9 set beats clear
    wr(12'h004, 106);
    rd(12'h014, 0, "R9 pre");
    wr(12'h01C, 32'hFFFFFFFF, 1);
    rd(12'h000, 106, "R9 count");
    rd(12'h014, 1, "R9 set priority");
    wr(12'h01C, 32'hDEAD);
    rd(12'h014, 0, "R9 clear data");
    // R6 immediate
    wr(12'h004, 106); rd(12'h014, 1, "R6 match write equal");
    wr(12'h01C, 0);
    wr(12'h004, 300); wr(12'h008, 300); rd(12'h014, 1, "R6 load write equal");
    wr(12'h01C, 0);
    wr(12'h008, 7); rd(12'h014, 0, "R6 load unequal");
    // R4 wrap
    wr(12'h008, 32'hFFFFFFFE); wr(12'h004, 0);
    rd(12'h014, 0, "R4 below not fired");
    tk(1); rd(12'h014, 0, "R4 not yet");
    tk(1);
    rd(12'h000, 0, "R4 wrapped count");
    rd(12'h014, 1, "R4 fired after wrap");
    wr(12'h01C, 0);
    // R13 clear read and undefined sweep
    rd(12'h01C, 0, "R13 clear reads zero");
    for (int a = 12'h020; a < 12'hFE0; a += 4) rd(12'(a), 0, "R13 undefined");
    // R11 ID table
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      case (i)
        0: e = 8'h31; 1: e = 8'h10; 2: e = 8'h14; 3: e = 8'h00;
        4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
      endcase
      rd(12'(12'hFE0 + 4 * i), {24'd0, e}, "R11 id byte");
    end
    finish_run();
  end
endmodule